// File: doc/BRIEF.md
# Scaled-Index Address Generator

This block forms a 64-bit effective address from up to four terms: a 32-bit signed displacement, a base value, an index value and a power-of-two scale applied to the index. The base and the index each come with an enable flag. When a term is switched off it contributes its neutral value, so the same datapath serves every addressing form from a bare displacement to the full base-plus-scaled-index-plus-offset sum.

A request is presented for one cycle with `req_valid_i`. One clock later the block shows the registered address with `addr_valid_o` high. A request that names register 4 (the stack pointer) as an enabled index is refused: the block raises `fault_o` for one cycle, leaves `addr_valid_o` low, and keeps the previous address. A kind bit goes with each request and comes back with the result. It says whether the address is meant for a memory access or is only handed back as a computed value. Both kinds give the same sum, and the block has no flag outputs at all.

Top module: `agen_scaled`

## Requirements
- R1: One cycle after an accepted request, `addr_o` equals sext(disp) + base + (index << scale), taken modulo 2^64, and `addr_valid_o` is high for that one cycle.
- R2: `scale_i` is a left-shift amount: code 0 multiplies the index by 1, code 1 by 2, code 2 by 4 and code 3 by 8.
- R3: With `base_en_i` low, the base term is zero whatever value `base_i` carries.
- R4: With `idx_en_i` low, the index term is zero and no fault is raised, whatever `idx_i`, `scale_i` and `idx_reg_i` carry (register 4 included).
- R5: `disp_i` is a two's-complement 32-bit value, sign-extended to 64 bits before the addition.
- R6: The sum wraps modulo 2^64, and nothing signals that it wrapped.
- R7: A request with `idx_en_i` high and `idx_reg_i` equal to 4 gives `fault_o` high and `addr_valid_o` low in the next cycle. `addr_o` and `kind_o` keep their previous values.
- R8: `kind_o` returns the `req_kind_i` of the accepted request (0 = memory access, 1 = value only). Both kinds produce the same address.
- R9: In a cycle after one with no request, `addr_valid_o` and `fault_o` are low and `addr_o` holds its value.
- R10: While `rst_n` is low, `addr_o`, `addr_valid_o`, `fault_o` and `kind_o` are all zero, taking effect without a clock edge. Reset is released through a two-stage synchronizer.
- R11: Requests on consecutive cycles each produce their own result on the following cycle, with no bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe |
| req_kind_i | input | 1 | 0 = memory access, 1 = value only |
| disp_i | input | 32 | Signed displacement |
| base_i | input | 64 | Base register value |
| base_en_i | input | 1 | Base term present |
| idx_i | input | 64 | Index register value |
| idx_en_i | input | 1 | Index term present |
| idx_reg_i | input | 4 | Register number of the index |
| scale_i | input | 2 | Index shift amount (0..3) |
| addr_o | output | 64 | Registered effective address |
| addr_valid_o | output | 1 | Address strobe |
| fault_o | output | 1 | Stack-pointer-as-index fault strobe |
| kind_o | output | 1 | Kind of the returned result |

## Verification
The result register updates in the cycle after a request, so a wrong term selection, sign extension or shift amount shows up as a wrong `addr_o` exactly one clock after the strobe. A broken enable on the result register shows up differently: the address moves during idle or faulting cycles, visible at the port in the next cycle. Fault decoding errors show as a one-cycle `fault_o` and `addr_valid_o` pair that disagrees with the index enable and register number of the request just before it. Reset faults appear at once as non-zero outputs while `rst_n` is low.

// File: rtl/agen_pkg.sv
package agen_pkg;

  typedef enum logic {
    KIND_MEM = 1'b0,
    KIND_VAL = 1'b1
  } agen_kind_e;

  localparam int unsigned AGEN_SP_REG = 4;

endpackage

// File: rtl/agen_rst_sync.sv
module agen_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/agen_index_scale.sv
module agen_index_scale #(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned REG_W   = 4,
  parameter int unsigned SCALE_W = 2,
  parameter int unsigned SP_REG  = 4
) (
  input  logic [ADDR_W-1:0]  idx_i,
  input  logic               idx_en_i,
  input  logic [REG_W-1:0]   idx_reg_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic [ADDR_W-1:0]  scaled_o,
  output logic               sp_fault_o
);

  localparam int unsigned N_SCALES = 1 << SCALE_W;

  logic [ADDR_W-1:0] gated_idx;
  logic [ADDR_W-1:0] shifted [N_SCALES];

  // A missing index contributes zero, so the scale code has no effect then.
  always_comb begin
    gated_idx = idx_en_i ? idx_i : '0;
  end

  // One fixed-shift candidate per scale code; the code picks one.
  for (genvar k = 0; k < N_SCALES; k++) begin : g_shift
    assign shifted[k] = gated_idx << k;
  end

  always_comb begin
    scaled_o = shifted[scale_i];
  end

  always_comb begin
    sp_fault_o = idx_en_i && (idx_reg_i == REG_W'(SP_REG));
  end

endmodule

// File: rtl/agen_sum.sv
module agen_sum #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DISP_W = 32
) (
  input  logic [DISP_W-1:0] disp_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              base_en_i,
  input  logic [ADDR_W-1:0] scaled_i,
  output logic [ADDR_W-1:0] sum_o
);

  localparam int unsigned EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] base_term;

  always_comb begin
    disp_ext  = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    base_term = base_en_i ? base_i : '0;
    sum_o     = disp_ext + base_term + scaled_i;
  end

endmodule

// File: rtl/agen_out_reg.sv
module agen_out_reg #(
  parameter int unsigned ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic              req_kind_i,
  input  logic              sp_fault_i,
  input  logic [ADDR_W-1:0] sum_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_valid_o,
  output logic              fault_o,
  output logic              kind_o
);

  logic              accept;
  logic [ADDR_W-1:0] addr_d;
  logic              valid_d;
  logic              fault_d;
  logic              kind_d;

  always_comb begin
    accept  = req_valid_i && !sp_fault_i;
    valid_d = accept;
    fault_d = req_valid_i && sp_fault_i;
    addr_d  = addr_o;
    kind_d  = kind_o;
    if (accept) begin
      addr_d = sum_i;
      kind_d = req_kind_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o       <= '0;
      kind_o       <= 1'b0;
      addr_valid_o <= 1'b0;
      fault_o      <= 1'b0;
    end else begin
      addr_o       <= addr_d;
      kind_o       <= kind_d;
      addr_valid_o <= valid_d;
      fault_o      <= fault_d;
    end
  end

  // R7
  valid_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_valid_o && fault_o));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> (!addr_valid_o && !fault_o));

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid_o |-> $stable(addr_o));

  // R8
  kind_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid_o |-> (kind_o == $past(req_kind_i)));

endmodule

// File: rtl/agen_scaled.sv
module agen_scaled
  import agen_pkg::*;
#(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned DISP_W  = 32,
  parameter int unsigned REG_W   = 4,
  parameter int unsigned SCALE_W = 2,
  parameter int unsigned SP_REG  = AGEN_SP_REG,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid_i,
  input  logic               req_kind_i,
  input  logic [DISP_W-1:0]  disp_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic               base_en_i,
  input  logic [ADDR_W-1:0]  idx_i,
  input  logic               idx_en_i,
  input  logic [REG_W-1:0]   idx_reg_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               addr_valid_o,
  output logic               fault_o,
  output logic               kind_o
);

  logic              rst_n_sync;
  logic [ADDR_W-1:0] scaled;
  logic              sp_fault;
  logic [ADDR_W-1:0] sum;

  agen_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_sync)
  );

  agen_index_scale #(
    .ADDR_W  (ADDR_W),
    .REG_W   (REG_W),
    .SCALE_W (SCALE_W),
    .SP_REG  (SP_REG)
  ) u_index (
    .idx_i      (idx_i),
    .idx_en_i   (idx_en_i),
    .idx_reg_i  (idx_reg_i),
    .scale_i    (scale_i),
    .scaled_o   (scaled),
    .sp_fault_o (sp_fault)
  );

  agen_sum #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W)
  ) u_sum (
    .disp_i    (disp_i),
    .base_i    (base_i),
    .base_en_i (base_en_i),
    .scaled_i  (scaled),
    .sum_o     (sum)
  );

  agen_out_reg #(
    .ADDR_W (ADDR_W)
  ) u_out (
    .clk          (clk),
    .rst_n        (rst_n_sync),
    .req_valid_i  (req_valid_i),
    .req_kind_i   (req_kind_i),
    .sp_fault_i   (sp_fault),
    .sum_i        (sum),
    .addr_o       (addr_o),
    .addr_valid_o (addr_valid_o),
    .fault_o      (fault_o),
    .kind_o       (kind_o)
  );

  // R7
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    fault_o |-> $past(req_valid_i && idx_en_i && (idx_reg_i == REG_W'(SP_REG))));

  // R4
  no_idx_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (req_valid_i && !idx_en_i) |=> !fault_o);

  // R1
  valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    addr_valid_o |-> $past(req_valid_i));

endmodule

// File: tb/agen_scaled_tb.sv
module agen_scaled_tb;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NVEC = 11;

  typedef struct packed {
    logic        kind;
    logic [31:0] disp;
    logic [63:0] base;
    logic        ben;
    logic [63:0] idx;
    logic        ien;
    logic [3:0]  ireg;
    logic [1:0]  sc;
    logic [63:0] eaddr;
    logic        efault;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 32'h0000_0010, 64'h1000, 1'b1, 64'h3, 1'b1, 4'd1, 2'd3, 64'h1028, 1'b0},
    '{1'b0, 32'hFFFF_FFF8, 64'h2000, 1'b1, 64'h0, 1'b0, 4'd0, 2'd0, 64'h1FF8, 1'b0},
    '{1'b0, 32'h0000_0000, 64'h0, 1'b0, 64'h100, 1'b1, 4'd2, 2'd2, 64'h400, 1'b0},
    '{1'b0, 32'h0000_0020, 64'hDEAD, 1'b0, 64'h0, 1'b0, 4'd0, 2'd0, 64'h20, 1'b0},
    '{1'b0, 32'h0000_0000, 64'h100, 1'b1, 64'h55, 1'b0, 4'd4, 2'd3, 64'h100, 1'b0},
    '{1'b0, 32'h0000_0002, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 64'h0, 1'b0, 4'd0, 2'd0, 64'h1, 1'b0},
    '{1'b1, 32'h0000_0040, 64'h40, 1'b1, 64'h9, 1'b1, 4'd4, 2'd1, 64'h1, 1'b1},
    '{1'b1, 32'h0000_0004, 64'h10, 1'b1, 64'h1, 1'b1, 4'd5, 2'd1, 64'h16, 1'b0},
    '{1'b0, 32'h8000_0000, 64'h0, 1'b0, 64'h0, 1'b0, 4'd0, 2'd0, 64'hFFFF_FFFF_8000_0000, 1'b0},
    '{1'b0, 32'h0000_0000, 64'h0, 1'b0, 64'h8000_0000_0000_0001, 1'b1, 4'd7, 2'd3, 64'h8, 1'b0},
    '{1'b0, 32'h0000_0000, 64'h0, 1'b0, 64'h7, 1'b1, 4'd0, 2'd0, 64'h7, 1'b0}
  };

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_kind;
  logic [31:0] disp;
  logic [63:0] base;
  logic        base_en;
  logic [63:0] idx;
  logic        idx_en;
  logic [3:0]  idx_reg;
  logic [1:0]  scale;
  logic [63:0] addr;
  logic        addr_valid;
  logic        fault;
  logic        kind;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  logic        last_kind = 1'b0;

  agen_scaled u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid_i  (req_valid),
    .req_kind_i   (req_kind),
    .disp_i       (disp),
    .base_i       (base),
    .base_en_i    (base_en),
    .idx_i        (idx),
    .idx_en_i     (idx_en),
    .idx_reg_i    (idx_reg),
    .scale_i      (scale),
    .addr_o       (addr),
    .addr_valid_o (addr_valid),
    .fault_o      (fault),
    .kind_o       (kind)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string vec_tag(int i);
    case (i)
      0: return "R1 R2 scale x8";
      1: return "R5 negative displacement";
      2: return "R2 R3 no base, scale x4";
      3: return "R3 base ignored";
      4: return "R4 disabled index reg 4";
      5: return "R6 wrap";
      6: return "R7 stack pointer index";
      7: return "R8 value kind";
      8: return "R5 most negative displacement";
      9: return "R2 R6 shifted-out index bit";
      default: return "R2 scale x1";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_valid = 1'b0;
    req_kind  = 1'b0;
    disp      = '0;
    base      = '0;
    base_en   = 1'b0;
    idx       = '0;
    idx_en    = 1'b0;
    idx_reg   = '0;
    scale     = '0;
  endtask

  task automatic drive_vec(input vec_t v);
    req_valid = 1'b1;
    req_kind  = v.kind;
    disp      = v.disp;
    base      = v.base;
    base_en   = v.ben;
    idx       = v.idx;
    idx_en    = v.ien;
    idx_reg   = v.ireg;
    scale     = v.sc;
  endtask

  task automatic check_vec(input vec_t v, input string tag);
    check({tag, " addr"},  addr, v.eaddr);
    check({tag, " valid"}, {63'd0, addr_valid}, {63'd0, !v.efault});
    check({tag, " fault"}, {63'd0, fault}, {63'd0, v.efault});
    if (!v.efault) last_kind = v.kind;
    check({tag, " kind"},  {63'd0, kind}, {63'd0, last_kind});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset addr",  addr, 64'h0);
    check("R10 reset valid", {63'd0, addr_valid}, 64'h0);
    check("R10 reset fault", {63'd0, fault}, 64'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Table walk: drive on one falling edge, check on the next.
    for (int i = 0; i < NVEC; i++) begin
      drive_vec(VECS[i]);
      @(negedge clk);
      idle_inputs();
      check_vec(VECS[i], vec_tag(i));
    end

    // R9: no request keeps strobes low and the address held
    @(negedge clk);
    check("R9 idle valid", {63'd0, addr_valid}, 64'h0);
    check("R9 idle fault", {63'd0, fault}, 64'h0);
    check("R9 idle addr hold", addr, 64'h7);

    // R11: back-to-back requests
    drive_vec(VECS[0]);
    @(negedge clk);
    check_vec(VECS[0], "R11 first of pair");
    drive_vec(VECS[7]);
    @(negedge clk);
    idle_inputs();
    check_vec(VECS[7], "R11 second of pair");

    // R8: same operands, memory kind, same address as value kind
    begin
      vec_t v;
      v = VECS[7];
      v.kind = 1'b0;
      drive_vec(v);
      @(negedge clk);
      idle_inputs();
      check_vec(v, "R8 memory kind same address");
    end

    // R7 followed by idle: fault lasts one cycle only
    drive_vec(VECS[6]);
    @(negedge clk);
    idle_inputs();
    check("R7 fault raised", {63'd0, fault}, 64'h1);
    check("R7 addr held", addr, 64'h16);
    @(negedge clk);
    check("R7 fault one cycle", {63'd0, fault}, 64'h0);

    // R10: asynchronous reset between edges
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    check("R10 async addr",  addr, 64'h0);
    check("R10 async kind",  {63'd0, kind}, 64'h0);
    check("R10 async valid", {63'd0, addr_valid}, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    last_kind = 1'b0;
    drive_vec(VECS[2]);
    @(negedge clk);
    idle_inputs();
    check_vec(VECS[2], "R10 after reset release");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule